// File: doc/BRIEF.md
# Card Socket Status Change Interrupt Unit

This unit watches the status pins of two removable-card sockets and turns changes on them into one interrupt line. Each socket drives eight pins: two voltage-sense pins, write protect, two card-detect pins, two battery-voltage pins and ready. All sixteen pins go through a synchroniser. Their present levels can be read back from a pin register. Transitions are recorded in a sticky change register, and an enable register chooses which recorded changes raise the interrupt. Both sockets share these three 32-bit registers. Socket A occupies the upper halfword and socket B the lower halfword, with the same layout in each.

Software reads the change register in its interrupt handler and clears the bits it has handled by writing ones to them. Card-detect changes are recorded only when both detect pins of a socket agree, so a card that is half inserted raises no event. The ready pin has four sources: a sticky rising-edge bit, a sticky falling-edge bit, and two live level bits (ready low, ready high) that track the pin and need no clearing. Each socket also has a control register that drives the card reset and buffer output-enable outputs.

Top module: `pccard_stat_irq`

## Requirements
- R1: After reset the enable register reads 0, every sticky change bit reads 0, irq is 0, card_reset is 2'b00 and card_oe_n is 2'b11. The only change-register bits that read 1 are the live ready-low bits of sockets whose ready pin is low.
- R2: The pin register (address 0) returns, within each halfword, VS1, VS2, WP, CD2, CD1, BVD2, BVD1 and RDY at bits 15 down to 8. Bits 7 to 0 of each halfword read 0. Socket A is bits 31:16 and socket B is bits 15:0. The register shows a pin level two clock edges after the pin changes.
- R3: Bits 15:14 of a socket's halfword form the voltage-sense code, with VS1 as the high bit. Code 1 is a 3.3 V-only card and code 2 is a low-voltage-only card.
- R4: In the change register (address 1), bits 15, 14, 13, 10, 9 and 8 of a halfword become 1 on the third clock edge after the matching pin changes level in either direction. They stay 1 after the pin returns to its old level.
- R5: A write to the change register clears each bit where the write data is 1 and the halfword is selected by bus_hmask. bus_hmask bit 1 selects bits 31:16 and bit 0 selects bits 15:0. A data bit of 0, or an unselected halfword, leaves the bit unchanged. If a new change and a clear reach the same bit in the same cycle, the new change wins.
- R6: Card-detect bits 12 (CD2) and 11 (CD1) of a halfword are both set together, and only when the synchronised CD2 and CD1 are equal and their common value differs from the last value on which they agreed. A change on one detect pin alone sets neither bit.
- R7: Bit 5 of a halfword sets on a rising ready edge and bit 4 sets on a falling ready edge. Bit 7 always equals the inverted synchronised ready level and bit 6 equals the synchronised ready level. Writing ones to bits 7 and 6 has no effect on them.
- R8: irq is 1 exactly when some bit of the change register, live level bits included, is 1 and the same bit of the enable register (address 2) is 1.
- R9: A write to the enable register updates only the halfwords selected by bus_hmask, so a write to one socket's half leaves the other socket's enable bits intact.
- R10: Control register A (address 3) drives socket A and control register B (address 4) drives socket B. In each, bit 6 is the active-high card reset (card_reset[0] for A, card_reset[1] for B) and bit 7 is the active-low output enable (card_oe_n[0] for A, card_oe_n[1] for B). A write needs bus_hmask bit 0 set. The bits read back in place and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_a | input | 8 | Socket A pins: VS1, VS2, WP, CD2, CD1, BVD2, BVD1, RDY at bits 7..0 |
| pins_b | input | 8 | Socket B pins, same order |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index: 0 pins, 1 change, 2 enable, 3 control A, 4 control B |
| bus_hmask | input | 2 | Halfword write select: bit 1 upper, bit 0 lower |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| irq | output | 1 | Status change interrupt |
| card_reset | output | 2 | Card reset per socket, active high |
| card_oe_n | output | 2 | Card buffer output enable per socket, active low |

## Verification
The hardest case to reach is the card-detect qualification. The two detect pins of one socket must be moved one at a time, and the change register must be observed between the moves, so the bench can tell a single-pin change, which is ignored, from the later agreeing change, which sets both bits. A second hard case is the timing of the interrupt against the synchroniser depth. The bench samples irq one cycle before the expected edge and again on it. It also writes ones to the live ready bits, to show they cannot be cleared.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int HALF_W  = 16;
  localparam int PIN_W   = 8;
  localparam int NSLOT   = 2;

  // bit positions inside one socket halfword
  localparam int B_VS1  = 15;
  localparam int B_VS2  = 14;
  localparam int B_WP   = 13;
  localparam int B_CD2  = 12;
  localparam int B_CD1  = 11;
  localparam int B_BVD2 = 10;
  localparam int B_BVD1 = 9;
  localparam int B_RDY  = 8;
  localparam int B_RLOW = 7;
  localparam int B_RHI  = 6;
  localparam int B_RRIS = 5;
  localparam int B_RFAL = 4;

  // pin vector offset: halfword bit minus this gives the pin index
  localparam int PIN_OFS = 8;

  localparam int CTL_RST = 6;
  localparam int CTL_OEN = 7;

  typedef enum logic [2:0] {
    RG_PINS = 3'd0,
    RG_CHG  = 3'd1,
    RG_EN   = 3'd2,
    RG_CTLA = 3'd3,
    RG_CTLB = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcc_slot_evt.sv
module pcc_slot_evt
  import pcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pin_s,
  input  logic [HALF_W-1:0] clr,
  output logic [HALF_W-1:0] chg
);
  localparam logic [HALF_W-1:0] LIVE_MASK = (HALF_W'(1) << B_RLOW) | (HALF_W'(1) << B_RHI);

  logic [PIN_W-1:0]  pin_q;
  logic [1:0]        cd_ok_q, cd_ok_nxt;
  logic [HALF_W-1:0] sticky_q, sticky_nxt, set_ev;
  logic [1:0]        cd_now;
  logic              cd_agree, rdy_s, rdy_q;

  assign cd_now   = {pin_s[B_CD2-PIN_OFS], pin_s[B_CD1-PIN_OFS]};
  assign cd_agree = cd_now[1] == cd_now[0];
  assign rdy_s    = pin_s[B_RDY-PIN_OFS];
  assign rdy_q    = pin_q[B_RDY-PIN_OFS];

  always_comb begin
    set_ev = '0;
    for (int k = 0; k < PIN_W; k++) begin
      if ((k + PIN_OFS != B_CD2) && (k + PIN_OFS != B_CD1))
        set_ev[k+PIN_OFS] = pin_s[k] ^ pin_q[k];
    end
    cd_ok_nxt = cd_ok_q;
    if (cd_agree && (cd_now != cd_ok_q)) begin
      set_ev[B_CD2] = 1'b1;
      set_ev[B_CD1] = 1'b1;
      cd_ok_nxt     = cd_now;
    end
    set_ev[B_RRIS] = rdy_s & ~rdy_q;
    set_ev[B_RFAL] = ~rdy_s & rdy_q;
    sticky_nxt = ((sticky_q & ~clr) | set_ev) & ~LIVE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= '0;
      cd_ok_q  <= '0;
      sticky_q <= '0;
    end else begin
      pin_q    <= pin_s;
      cd_ok_q  <= cd_ok_nxt;
      sticky_q <= sticky_nxt;
    end
  end

  always_comb begin
    chg         = sticky_q;
    chg[B_RLOW] = ~rdy_s;
    chg[B_RHI]  = rdy_s;
  end

  // R5: a clear with no concurrent event empties the bit
  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[B_WP] && !set_ev[B_WP]) |=> !sticky_q[B_WP]);

  // R4: with no event and no clear a sticky bit holds
  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev[B_BVD1] && !clr[B_BVD1]) |=> $stable(sticky_q[B_BVD1]));

  // R6: detect pins that disagree never raise a detect event
  assert_cd_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_now[1] != cd_now[0]) |=> !$rose(sticky_q[B_CD2]));

  // R7: a rising ready edge is recorded in the next cycle
  assert_rdy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_s && !rdy_q) |=> sticky_q[B_RRIS]);
endmodule

// File: rtl/pccard_stat_irq.sv
module pccard_stat_irq
  import pcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pins_a,
  input  logic [7:0]  pins_b,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [1:0]  bus_hmask,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic [1:0]  card_reset,
  output logic [1:0]  card_oe_n
);
  localparam int REG_W = NSLOT * HALF_W;
  localparam int ALL_P = NSLOT * PIN_W;

  logic [ALL_P-1:0] pins_s;
  logic [REG_W-1:0] wmask, clr_all, chg_all, pin_view;
  logic [REG_W-1:0] en_q, en_nxt;
  logic [1:0]       ctl_q [NSLOT];
  logic [1:0]       ctl_nxt [NSLOT];
  logic             wr;
  reg_sel_e         sel;

  assign sel   = reg_sel_e'(bus_addr);
  assign wr    = bus_sel & bus_wr;
  assign wmask = {{HALF_W{bus_hmask[1]}}, {HALF_W{bus_hmask[0]}}};

  pcc_sync #(.W(ALL_P), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pins_a, pins_b}), .q(pins_s)
  );

  assign clr_all = (wr && sel == RG_CHG) ? (bus_wdata & wmask) : '0;

  genvar i;
  generate
    for (i = 0; i < NSLOT; i++) begin : g_slot
      localparam int POS = NSLOT - 1 - i;
      pcc_slot_evt u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_s (pins_s[POS*PIN_W +: PIN_W]),
        .clr   (clr_all[POS*HALF_W +: HALF_W]),
        .chg   (chg_all[POS*HALF_W +: HALF_W])
      );
      assign pin_view[POS*HALF_W +: HALF_W] = {pins_s[POS*PIN_W +: PIN_W], {(HALF_W-PIN_W){1'b0}}};

      always_comb begin
        ctl_nxt[i] = ctl_q[i];
        if (wr && bus_hmask[0] && (bus_addr == 3'(RG_CTLA) + 3'(i)))
          ctl_nxt[i] = {bus_wdata[CTL_OEN], bus_wdata[CTL_RST]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q[i] <= 2'b10;
        else        ctl_q[i] <= ctl_nxt[i];
      end

      assign card_oe_n[i]  = ctl_q[i][1];
      assign card_reset[i] = ctl_q[i][0];
    end
  endgenerate

  always_comb begin
    en_nxt = en_q;
    if (wr && sel == RG_EN) en_nxt = (en_q & ~wmask) | (bus_wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;
  end

  assign irq = |(chg_all & en_q);

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RG_PINS: bus_rdata = pin_view;
      RG_CHG:  bus_rdata = chg_all;
      RG_EN:   bus_rdata = en_q;
      RG_CTLA: bus_rdata = 32'({ctl_q[0], 6'b0});
      RG_CTLB: bus_rdata = 32'({ctl_q[1], 6'b0});
      default: bus_rdata = '0;
    endcase
  end

  // R9: an upper-half-only enable write leaves socket B's enables
  assert_en_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == RG_EN && bus_hmask == 2'b10) |=> $stable(en_q[HALF_W-1:0]));

  // R8: with no enable set the interrupt stays low
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R10: a control write to socket A never touches socket B
  assert_ctl_iso_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == RG_CTLA) |=> $stable(ctl_q[1]));
endmodule

// File: tb/pccard_stat_irq_test.sv
module pccard_stat_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins_a = '0, pins_b = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_hmask = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [1:0]  card_reset, card_oe_n;
  int checks = 0, errors = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  pccard_stat_irq uut (
    .clk(clk), .rst_n(rst_n), .pins_a(pins_a), .pins_b(pins_b),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_hmask(bus_hmask), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .card_reset(card_reset), .card_oe_n(card_oe_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] hm, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_hmask = hm; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_hmask = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] a, input logic [7:0] b, input int waitn);
    @(negedge clk);
    pins_a = a; pins_b = b;
    repeat (waitn) @(negedge clk);
  endtask

  task automatic quiesce();
    set_pins(8'h00, 8'h00, 4);
    wr(3'd1, 2'b11, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk("R1 card_oe_n", 32'(card_oe_n), 32'h3);
    chk("R1 card_reset", 32'(card_reset), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(3'd2, d); chk("R1 enable", d, 32'h0);
    rd(3'd1, d); chk("R1 change", d, 32'h0080_0080);
  endtask

  task automatic t_pins();
    set_pins(8'b0110_0011, 8'b1001_0100, 2);
    rd(3'd0, d); chk("R2 pin register", d, 32'h6300_9400);
    chk("R3 vs code slot A", 32'(d[31:30]), 32'd1);
    chk("R3 vs code slot B", 32'(d[15:14]), 32'd2);
    quiesce();
  endtask

  task automatic t_change();
    set_pins(8'h20, 8'h02, 3);
    rd(3'd1, d); chk("R4 change after transition", d, 32'h2080_0280);
    set_pins(8'h00, 8'h00, 3);
    rd(3'd1, d); chk("R4 change is sticky", d, 32'h2080_0280);
  endtask

  task automatic t_clear();
    wr(3'd1, 2'b11, 32'h0000_0200);
    rd(3'd1, d); chk("R5 write-one clears", d, 32'h2080_0080);
    wr(3'd1, 2'b11, 32'h0000_0000);
    rd(3'd1, d); chk("R5 write-zero keeps", d, 32'h2080_0080);
    wr(3'd1, 2'b01, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R5 unselected half keeps", d, 32'h2080_0080);
    quiesce();
  endtask

  task automatic t_detect();
    set_pins(8'h08, 8'h00, 3);
    rd(3'd1, d); chk("R6 single detect pin ignored", d, 32'h0080_0080);
    set_pins(8'h18, 8'h00, 3);
    rd(3'd1, d); chk("R6 agreeing detect sets both", d, 32'h1880_0080);
    quiesce();
  endtask

  task automatic t_ready();
    set_pins(8'h00, 8'h01, 3);
    rd(3'd1, d); chk("R7 ready rise", d, 32'h0080_0160);
    set_pins(8'h00, 8'h00, 3);
    rd(3'd1, d); chk("R7 ready fall", d, 32'h0080_01B0);
    wr(3'd1, 2'b11, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R7 live level not cleared", d, 32'h0080_0080);
  endtask

  task automatic t_irq();
    chk("R8 irq idle", 32'(irq), 32'h0);
    wr(3'd2, 2'b11, 32'h0080_0000);
    #1 chk("R8 irq from live ready-low", 32'(irq), 32'h1);
    wr(3'd2, 2'b11, 32'h0000_2000);
    #1 chk("R8 irq off after enable change", 32'(irq), 32'h0);
    @(negedge clk);
    pins_b = 8'h20;
    repeat (2) @(negedge clk);
    chk("R8 irq not before third edge", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R8 irq on enabled change", 32'(irq), 32'h1);
  endtask

  task automatic t_enable();
    wr(3'd2, 2'b10, 32'hFFFF_0000);
    rd(3'd2, d); chk("R9 upper write keeps lower", d, 32'hFFFF_2000);
    wr(3'd2, 2'b01, 32'h0000_0000);
    rd(3'd2, d); chk("R9 lower write keeps upper", d, 32'hFFFF_0000);
    wr(3'd2, 2'b11, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(3'd3, 2'b01, 32'h0000_0040);
    chk("R10 slot A reset", 32'(card_reset), 32'h1);
    chk("R10 slot A oe", 32'(card_oe_n), 32'h2);
    rd(3'd3, d); chk("R10 ctl A readback", d, 32'h40);
    wr(3'd4, 2'b01, 32'h0000_00C0);
    chk("R10 slot B reset", 32'(card_reset), 32'h3);
    chk("R10 slot B oe", 32'(card_oe_n), 32'h2);
    wr(3'd3, 2'b10, 32'h0000_0080);
    chk("R10 hmask bit0 required", 32'(card_oe_n), 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pins();
    t_change();
    t_clear();
    t_detect();
    t_ready();
    t_irq();
    t_enable();
    t_ctrl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule